// File: doc/BRIEF.md
# Dual-Channel Relative Phase Meter

This block compares the phase of two synchronised baseband I/Q streams. Both channels share one clock and one valid strobe. It keeps one sample out of every group of input samples, and it finds the angle of each kept sample on both channels with a pipelined vectoring CORDIC. It then subtracts the angle of channel 2 from the angle of channel 1 and removes a programmable calibration constant. It smooths the result over the three most recent values and delivers one relative-phase word for each kept sample, with a valid flag.

Every angle is an unsigned 16-bit fraction of a full turn. The value 65536 stands for 360 degrees, and angles increase counter-clockwise from the positive I axis. Because of this format, modular arithmetic moves a negative difference into the upper half of the range and also makes the offset subtraction wrap. The smoothing stage measures every sample in its window relative to the newest one. A run of results that crosses the 0/360 degree seam therefore averages near the seam and not near 180 degrees.

Top module: `relphase_meter`

## Requirements
- R1: Out of every DECIM (default 3) input samples with `in_valid` high, only the first one is used: samples number 0, DECIM, 2·DECIM and so on after reset, counted on valid cycles only. The block makes one result per kept sample.
- R2: The raw relative phase is the angle of channel 1 minus the angle of channel 2. An angle is atan2(Q, I) expressed in units of 1/65536 turn. The result is accurate to within 24 units.
- R3: A negative raw difference comes out as that difference plus 65536. For example, channel 1 at 10 degrees and channel 2 at 100 degrees give about 49152.
- R4: `cal_offset` is subtracted from the relative phase modulo 65536. An offset larger than the raw difference wraps into the upper range.
- R5: A new `cal_offset` value is used from the next kept sample onward. Results already in the smoothing window keep the offset they were formed with, and the pipeline is not flushed.
- R6: `phase_out` is the average of the three most recent corrected results, each taken as its signed distance from the newest one, divided by 3 and wrapped modulo 65536.
- R7: A channel sample with I = Q = 0 counts as angle 0. `zero_flag` is high with any output whose three-sample window contains such a sample.
- R8: During reset and after it, `phase_valid` stays low until three kept samples have passed through the chain. While `phase_valid` is low, `phase_out` and `zero_flag` are 0 after reset.
- R9: The angle is correct in all four quadrants, including inputs with negative I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Both channels carry a new sample |
| ch1_i | input | IQ_W | Channel 1 in-phase, signed |
| ch1_q | input | IQ_W | Channel 1 quadrature, signed |
| ch2_i | input | IQ_W | Channel 2 in-phase, signed |
| ch2_q | input | IQ_W | Channel 2 quadrature, signed |
| cal_offset | input | 16 | Calibration phase subtracted from the result, in units of 1/65536 turn |
| phase_valid | output | 1 | `phase_out` holds a new result |
| phase_out | output | 16 | Smoothed, corrected relative phase, in units of 1/65536 turn |
| zero_flag | output | 1 | The window of this result contains an all-zero channel sample |

## Verification
The stimulus covers several input patterns, and each one separates a different fault.

- **Sweep:** channel 1 steps through every quadrant against a fixed channel 2. This separates a correct quadrant pre-rotation from one that folds negative-I inputs, and it exposes a swapped subtraction order.
- **Decimation groups:** the position-0 sample of each group differs from its two neighbours, so keeping the wrong sample in the group shows up at once. Some groups arrive with idle cycles in between.
- **Offsets and seam:**
  - Pairs whose raw difference is negative test the unsigned mapping.
  - An offset larger than the raw difference tests the modular subtraction.
  - Results that alternate across 0/360 degrees separate the unwrapped average from a naive one.
- **Zero input and offset change:** all-zero samples on one or both channels test the defined angle and the flag window. An offset change between bursts shows whether the smoothing history is kept.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
   localparam int PH_W   = 16;
   localparam int ATAN_N = 16;

   // arctan(2^-k) in units of 1/65536 turn
   function automatic logic [PH_W-1:0] atan_step(input int k);
      case (k)
         0:  return 16'd8192;
         1:  return 16'd4836;
         2:  return 16'd2555;
         3:  return 16'd1297;
         4:  return 16'd651;
         5:  return 16'd326;
         6:  return 16'd163;
         7:  return 16'd81;
         8:  return 16'd41;
         9:  return 16'd20;
         10: return 16'd10;
         11: return 16'd5;
         12: return 16'd3;
         13: return 16'd1;
         14: return 16'd1;
         default: return 16'd0;
      endcase
   endfunction
endpackage

// File: rtl/rpm_decim.sv
module rpm_decim #(
   parameter int DW    = 64,
   parameter int DECIM = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);
   localparam int CW = (DECIM > 1) ? $clog2(DECIM) : 1;

   if (DECIM < 1) begin : g_bad_decim
      $error("rpm_decim: DECIM must be at least 1");
   end

   logic [CW-1:0] slot;
   logic          take;

   assign take = in_valid && (slot == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot      <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= take;
         if (take) out_data <= in_data;
         if (in_valid) slot <= (slot == CW'(DECIM - 1)) ? '0 : slot + 1'b1;
      end
   end

   // R1: a kept sample always comes from a valid input cycle
   a_r1_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   if (DECIM > 1) begin : g_gap_chk
      // R1: two kept samples are never back to back
      a_r1_gap: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |=> !out_valid);
   end
endmodule

// File: rtl/rpm_cordic.sv
module rpm_cordic #(
   parameter int WI   = 16,
   parameter int ITER = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic signed [WI-1:0]      in_i,
   input  logic signed [WI-1:0]      in_q,
   output logic                      out_valid,
   output logic [rpm_pkg::PH_W-1:0]  out_phase,
   output logic                      out_zero
);
   localparam int XW   = WI + 2;
   localparam int PW   = rpm_pkg::PH_W;
   localparam logic [PW-1:0] QUARTER = PW'(1) << (PW - 2);

   if (ITER < 2 || ITER > rpm_pkg::ATAN_N) begin : g_bad_iter
      $error("rpm_cordic: ITER out of range");
   end

   logic signed [XW-1:0] xs [0:ITER-1];
   logic signed [XW-1:0] ys [0:ITER-1];
   logic [PW-1:0]        zs [0:ITER];
   logic                 vs [0:ITER];
   logic                 zf [0:ITER];
   logic signed [XW-1:0] xi, yi;

   assign xi = XW'(in_i);
   assign yi = XW'(in_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < ITER; k++) begin
            xs[k] <= '0;
            ys[k] <= '0;
         end
         for (int k = 0; k <= ITER; k++) begin
            zs[k] <= '0;
            vs[k] <= 1'b0;
            zf[k] <= 1'b0;
         end
      end else begin
         // quadrant pre-rotation into the right half plane
         vs[0] <= in_valid;
         zf[0] <= (in_i == '0) && (in_q == '0);
         if (xi < 0) begin
            if (yi >= 0) begin
               xs[0] <= yi;  ys[0] <= -xi; zs[0] <= QUARTER;
            end else begin
               xs[0] <= -yi; ys[0] <= xi;  zs[0] <= -QUARTER;
            end
         end else begin
            xs[0] <= xi; ys[0] <= yi; zs[0] <= '0;
         end
         for (int k = 0; k < ITER; k++) begin
            vs[k+1] <= vs[k];
            zf[k+1] <= zf[k];
            if (ys[k] >= 0) begin
               zs[k+1] <= zs[k] + rpm_pkg::atan_step(k);
               if (k < ITER - 1) begin
                  xs[k+1] <= xs[k] + (ys[k] >>> k);
                  ys[k+1] <= ys[k] - (xs[k] >>> k);
               end
            end else begin
               zs[k+1] <= zs[k] - rpm_pkg::atan_step(k);
               if (k < ITER - 1) begin
                  xs[k+1] <= xs[k] - (ys[k] >>> k);
                  ys[k+1] <= ys[k] + (xs[k] >>> k);
               end
            end
         end
      end
   end

   assign out_valid = vs[ITER];
   assign out_zero  = zf[ITER];
   assign out_phase = zf[ITER] ? '0 : zs[ITER];

   // R9: after the pre-rotation the vector stays in the right half plane
   a_r9_right_half: assert property (@(posedge clk) disable iff (!rst_n)
      vs[ITER-1] |-> (xs[ITER-1] >= 0));
endmodule

// File: rtl/rpm_avg3.sv
module rpm_avg3 #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [PW-1:0] in_phase,
   input  logic          in_zero,
   output logic          out_valid,
   output logic [PW-1:0] out_phase,
   output logic          out_zero
);
   localparam int SW    = PW + 2;
   localparam int MW    = SW + PW + 2;
   localparam int RECIP = ((1 << PW) + 2) / 3;

   logic [PW-1:0]        h0, h1;
   logic                 hz0, hz1;
   logic [1:0]           fill;
   logic signed [PW-1:0] d0, d1;
   logic signed [SW-1:0] dsum;
   logic signed [MW-1:0] prod;
   logic [PW-1:0]        avg_next;

   always_comb begin
      d0       = $signed(h0 - in_phase);
      d1       = $signed(h1 - in_phase);
      dsum     = SW'(d0) + SW'(d1);
      prod     = MW'(dsum) * $signed(MW'(RECIP));
      avg_next = in_phase + PW'((prod + (MW'(1) <<< (PW - 1))) >>> PW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h0 <= '0; h1 <= '0; hz0 <= 1'b0; hz1 <= 1'b0;
         fill      <= '0;
         out_valid <= 1'b0;
         out_phase <= '0;
         out_zero  <= 1'b0;
      end else begin
         out_valid <= in_valid && (fill == 2'd2);
         if (in_valid) begin
            h1  <= h0;  h0  <= in_phase;
            hz1 <= hz0; hz0 <= in_zero;
            if (fill != 2'd2) fill <= fill + 2'd1;
            if (fill == 2'd2) begin
               out_phase <= avg_next;
               out_zero  <= in_zero | hz0 | hz1;
            end
         end
      end
   end

   // R6: each averaged result is triggered by a fresh input
   a_r6_result_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
endmodule

// File: rtl/relphase_meter.sv
module relphase_meter #(
   parameter int IQ_W  = 16,
   parameter int DECIM = 3,
   parameter int ITER  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [IQ_W-1:0]   ch1_i,
   input  logic signed [IQ_W-1:0]   ch1_q,
   input  logic signed [IQ_W-1:0]   ch2_i,
   input  logic signed [IQ_W-1:0]   ch2_q,
   input  logic [rpm_pkg::PH_W-1:0] cal_offset,
   output logic                     phase_valid,
   output logic [rpm_pkg::PH_W-1:0] phase_out,
   output logic                     zero_flag
);
   localparam int PW = rpm_pkg::PH_W;
   localparam int DW = 4 * IQ_W;
   localparam int NCH = 2;

   logic          dec_valid;
   logic [DW-1:0] dec_data;
   logic          ch_valid [NCH];
   logic [PW-1:0] ch_phase [NCH];
   logic          ch_zero  [NCH];
   logic          d_valid, d_zero;
   logic [PW-1:0] d_phase;

   rpm_decim #(.DW(DW), .DECIM(DECIM)) u_decim (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data({ch1_i, ch1_q, ch2_i, ch2_q}),
      .out_valid(dec_valid), .out_data(dec_data)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      localparam int BASE = (NCH - 1 - c) * 2 * IQ_W;
      rpm_cordic #(.WI(IQ_W), .ITER(ITER)) u_cordic (
         .clk(clk), .rst_n(rst_n),
         .in_valid(dec_valid),
         .in_i($signed(dec_data[BASE + IQ_W +: IQ_W])),
         .in_q($signed(dec_data[BASE +: IQ_W])),
         .out_valid(ch_valid[c]), .out_phase(ch_phase[c]), .out_zero(ch_zero[c])
      );
   end

   // difference, wrap to full turn and calibration, all modulo 2^PW
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_valid <= 1'b0;
         d_phase <= '0;
         d_zero  <= 1'b0;
      end else begin
         d_valid <= ch_valid[0];
         d_phase <= ch_phase[0] - ch_phase[1] - cal_offset;
         d_zero  <= ch_zero[0] | ch_zero[1];
      end
   end

   rpm_avg3 #(.PW(PW)) u_avg (
      .clk(clk), .rst_n(rst_n),
      .in_valid(d_valid), .in_phase(d_phase), .in_zero(d_zero),
      .out_valid(phase_valid), .out_phase(phase_out), .out_zero(zero_flag)
   );

   // checker state: differences seen since reset, saturating at 3
   logic [1:0] chk_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_seen <= '0;
      else if (d_valid && chk_seen != 2'd3) chk_seen <= chk_seen + 2'd1;
   end

   // R8: no output before three kept samples have reached the averager
   a_r8_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
      phase_valid |-> (chk_seen == 2'd3));

   // R2: both channel angles leave their pipelines together
   a_r2_chan_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      ch_valid[0] == ch_valid[1]);
endmodule

// File: tb/relphase_meter_tb.sv
module relphase_meter_tb;
   localparam real PI  = 3.14159265358979;
   localparam real TOL = 24.0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [15:0] ch1_i = '0, ch1_q = '0, ch2_i = '0, ch2_q = '0;
   logic [15:0] cal_offset = '0;
   logic phase_valid, zero_flag;
   logic [15:0] phase_out;

   relphase_meter u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .ch1_i(ch1_i), .ch1_q(ch1_q), .ch2_i(ch2_i), .ch2_q(ch2_q),
      .cal_offset(cal_offset),
      .phase_valid(phase_valid), .phase_out(phase_out), .zero_flag(zero_flag)
   );

   always #4 clk = ~clk;

   typedef struct { real ph; bit z; string tag; } exp_t;
   exp_t  expq[$];
   int    checks = 0, errors = 0, outs = 0;
   int    in_cnt = 0, wn = 0;
   real   win[3];
   bit    wz[3];
   string cur_tag = "R8";

   function automatic real wrap_s(input real v);
      real r = v;
      while (r >= 32768.0) r -= 65536.0;
      while (r < -32768.0) r += 65536.0;
      return r;
   endfunction

   function automatic real wrap_u(input real v);
      real r = v;
      while (r >= 65536.0) r -= 65536.0;
      while (r < 0.0) r += 65536.0;
      return r;
   endfunction

   function automatic real ang(input int i, input int q);
      if (i == 0 && q == 0) return 0.0;
      return wrap_u($atan2(real'(q), real'(i)) * 65536.0 / (2.0 * PI));
   endfunction

   task automatic model(input int i1, q1, i2, q2);
      real r;
      exp_t e;
      if (in_cnt % 3 == 0) begin
         r = wrap_u(ang(i1, q1) - ang(i2, q2) - real'(cal_offset));
         win[2] = win[1]; win[1] = win[0]; win[0] = r;
         wz[2] = wz[1]; wz[1] = wz[0];
         wz[0] = (i1 == 0 && q1 == 0) || (i2 == 0 && q2 == 0);
         if (wn < 3) wn++;
         if (wn == 3) begin
            e.ph  = wrap_u(win[0] + (wrap_s(win[1] - win[0]) + wrap_s(win[2] - win[0])) / 3.0);
            e.z   = wz[0] | wz[1] | wz[2];
            e.tag = cur_tag;
            expq.push_back(e);
         end
      end
      in_cnt++;
   endtask

   task automatic send(input int i1, q1, i2, q2);
      @(negedge clk);
      in_valid = 1'b1;
      ch1_i = 16'(i1); ch1_q = 16'(q1); ch2_i = 16'(i2); ch2_q = 16'(q2);
      model(i1, q1, i2, q2);
   endtask

   task automatic send_deg(input real a1, input real a2, input real amp);
      send(int'($rtoi(amp * $cos(a1 * PI / 180.0) + (amp * $cos(a1 * PI / 180.0) >= 0 ? 0.5 : -0.5))),
           int'($rtoi(amp * $sin(a1 * PI / 180.0) + (amp * $sin(a1 * PI / 180.0) >= 0 ? 0.5 : -0.5))),
           int'($rtoi(amp * $cos(a2 * PI / 180.0) + (amp * $cos(a2 * PI / 180.0) >= 0 ? 0.5 : -0.5))),
           int'($rtoi(amp * $sin(a2 * PI / 180.0) + (amp * $sin(a2 * PI / 180.0) >= 0 ? 0.5 : -0.5))));
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what, input real act, input real exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && phase_valid) begin
         exp_t e;
         outs++;
         if (expq.size() == 0) begin
            check(1'b0, cur_tag, "unexpected output", real'(phase_out), -1.0);
         end else begin
            real dv;
            e  = expq.pop_front();
            dv = wrap_s(real'(phase_out) - e.ph);
            check((dv <= TOL) && (dv >= -TOL), e.tag, "phase", real'(phase_out), e.ph);
            check(zero_flag == e.z, e.tag, "zero_flag", real'(zero_flag), real'(e.z));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(phase_valid == 1'b0 && phase_out == 16'd0 && zero_flag == 1'b0, "R8",
            "state in reset", real'(phase_out), 0.0);
      rst_n = 1'b1;
      idle(2);
      check(phase_valid == 1'b0, "R8", "valid after reset", real'(phase_valid), 0.0);

      // R8: two kept samples must not produce a result
      cur_tag = "R8";
      for (int k = 0; k < 6; k++) send_deg(40.0, 10.0, 20000.0);
      idle(40);
      check(outs == 0, "R8", "outputs after two kept samples", real'(outs), 0.0);
      for (int k = 0; k < 3; k++) send_deg(40.0, 10.0, 20000.0);
      idle(40);
      check(outs == 1, "R8", "outputs after three kept samples", real'(outs), 1.0);

      // R1: position 0 of each group differs from its neighbours; some gaps
      cur_tag = "R1";
      for (int g = 0; g < 12; g++) begin
         send_deg(30.0 * g, 15.0, 20000.0);
         if (g % 3 == 1) idle(1);
         send_deg(200.0, 15.0 + 7.0 * g, 20000.0);
         send_deg(100.0 + g, 300.0, 20000.0);
         if (g % 4 == 0) idle(2);
      end

      // R2 R9: sweep all quadrants of channel 1 against fixed channel 2
      cur_tag = "R2 R9";
      for (int a = 0; a < 360; a += 15)
         for (int k = 0; k < 9; k++) send_deg(real'(a) + 0.3, 20.0, 5000.0 + 1000.0 * (a % 4));

      // R3: negative raw difference maps to the upper range
      cur_tag = "R3";
      for (int k = 0; k < 12; k++) send_deg(10.0, 100.0, 20000.0);
      for (int k = 0; k < 12; k++) send_deg(-170.0, 170.0, 20000.0);
      idle(40);

      // R4: calibration offset, including wrap below zero
      cur_tag = "R4";
      cal_offset = 16'd1000;
      for (int k = 0; k < 12; k++) send_deg(50.0, 20.0, 20000.0);
      for (int k = 0; k < 12; k++) send_deg(75.0, 75.0, 20000.0);
      idle(40);

      // R5: change offset between bursts, history kept
      cur_tag = "R5";
      for (int k = 0; k < 6; k++) send_deg(120.0, 30.0, 20000.0);
      idle(40);
      cal_offset = 16'd546;
      for (int k = 0; k < 12; k++) send_deg(120.0, 30.0, 20000.0);
      idle(40);
      cal_offset = 16'd0;

      // R6: results alternating across the 0/360 seam
      cur_tag = "R6";
      for (int k = 0; k < 30; k++) begin
         real r;
         r = ((k / 3) % 3 == 0) ? 359.0 : (((k / 3) % 3 == 1) ? 1.0 : 0.5);
         send_deg(r + 40.0, 40.0, 20000.0);
      end
      for (int k = 0; k < 18; k++) send_deg(((k / 3) % 2 == 0) ? 178.0 : 184.0, 0.0, 20000.0);

      // R7: all-zero sample on one or both channels
      cur_tag = "R7";
      for (int k = 0; k < 9; k++) send_deg(60.0, 0.0, 20000.0);
      send(0, 0, 14000, 14000);
      send(1, 1, 1, 1); send(1, 1, 1, 1);
      for (int k = 0; k < 12; k++) send_deg(60.0, 0.0, 20000.0);
      send(0, 0, 0, 0); idle(1); send(5, 5, 5, 5); send(5, 5, 5, 5);
      for (int k = 0; k < 12; k++) send_deg(60.0, 0.0, 20000.0);

      idle(60);
      check(expq.size() == 0, "R1", "results missing at end", real'(expq.size()), 0.0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule